// File: doc/BRIEF.md
# Tag-Side Session and Memory Protocol Controller

This block is the protocol engine of an emulated contactless memory tag. It talks to a bit-level frame receiver and a frame sender through one-cycle start/done pulses. It never touches the air interface itself. After a session opens, it steers a keystream generator: it clears the generator's seed for a new session, then loads the initialisation value that the reader sends. It also tells the shared slot timer to skip one bit period once the handshake is complete.

A session opens with a three-frame exchange. The reader sends an initialisation value. The tag answers with a code that names its size class. The reader confirms with an acknowledge code. After that, every received frame is either a read or a write, and the frame length alone decides which. Reads return the stored byte together with a 4-bit check code. Writes carry their own check code, which is verified before the byte is stored. Any malformed frame ends the session, and the controller then starts listening for a new one.

The byte store holds up to 1024 bytes. A host port can preload it whenever the controller is not using the store.

Top module: `tag_session_ctrl`

## Requirements
- R1: The tag-type input selects the size class: 0 gives a 6-bit command and 5-bit address, 1 gives a 9-bit command and 8-bit address, 2 gives an 11-bit command and 10-bit address. While the input is 3, no session starts and `rx_start` stays low. The type is latched when a session opens.
- R2: Each new session begins with one cycle in which `ks_load` is high with `ks_seed` = 0 and `rx_start` is high.
- R3: If the first received frame is exactly 7 bits with no error, the controller pulses `ks_load` with `ks_seed` equal to that frame. In the same cycle it pulses `tx_start` with `tx_len` = 6 and `tx_frame` set to 0x0D, 0x1D or 0x3D for types 0, 1 and 2. Any other first frame restarts the session as in R2.
- R4: The frame received after the card code must be 6 bits and equal 0x19 for type 0, or 0x39 for types 1 and 2. Otherwise the session restarts as in R2.
- R5: A successful acknowledge produces a one-cycle `ts_bump` pulse. The pulse comes together with the `rx_start` for the first command and without `ks_load`.
- R6: A command frame whose length equals the command size is a read. The address is frame bits [address size:1]. The reply has `tx_len` = 12, the stored byte in `tx_frame[7:0]` and the check code in `tx_frame[11:8]`. After the reply is sent, the next command is requested.
- R7: The check code is computed over the (8 + command size)-bit word formed as (byte << command size) | command, taking the most significant bit first. The register starts at 0x5. For each bit, feedback = bit XOR reg[3], and reg becomes (reg << 1) XOR (feedback ? 0xC : 0), kept to 4 bits. There is no final inversion.
- R8: A frame of command size + 12 bits is a write. The address is bits [address size:1], the data byte sits just above the command bits, and the check code occupies the top 4 bits. If the check code equals the R7 code over (data << command size) | (address << 1), the byte is stored and a plain acknowledge is sent: `tx_len` = 1, `tx_frame` = 1 and `tx_plain` high.
- R9: A write whose check code does not match leaves the memory unchanged and restarts the session as in R2.
- R10: In the command phase, a frame of any other length, or a frame with `rx_err` set, restarts the session as in R2.
- R11: `host_we` writes `host_data` at `host_addr` in any cycle in which the controller is not accessing the store.
- R12: During reset, `rx_start`, `tx_start`, `tx_plain`, `ks_load` and `ts_bump` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_type | input | 2 | Size class select (0, 1, 2; 3 is invalid) |
| rx_start | output | 1 | Request for the receiver to capture the next frame |
| rx_done | input | 1 | Receiver has finished a frame |
| rx_err | input | 1 | Received frame was malformed |
| rx_len | input | 5 | Number of bits received |
| rx_frame | input | 23 | Received bits, first bit at bit 0 |
| tx_start | output | 1 | Request for the sender to transmit a frame |
| tx_len | output | 4 | Number of bits to send |
| tx_frame | output | 12 | Bits to send, first bit at bit 0 |
| tx_plain | output | 1 | Send without keystream whitening |
| tx_done | input | 1 | Sender has finished the frame |
| ks_load | output | 1 | Load `ks_seed` into the keystream generator |
| ks_seed | output | 7 | Seed value for the keystream generator |
| ts_bump | output | 1 | Advance the shared slot timer by one bit period |
| host_we | input | 1 | Host preload write enable |
| host_addr | input | 10 | Host preload address |
| host_data | input | 8 | Host preload data |

## Verification
A state register that wanders off its path usually shows up within one frame exchange. Either a session restart appears as a stray `ks_load` with seed 0 where a command request was expected, or a reply comes back with the wrong length. A wrong field slice or check-code bit order shows up in the very first reply: the 12-bit read frame no longer matches the value the bench computes from the stored byte. A write with a false match shows up on the next read of that address, because the stored byte has changed when it should not have.

// File: rtl/tag_sess_pkg.sv
package tag_sess_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_IV, ST_TYPE_TX, ST_ACK, ST_CMD,
        ST_RD, ST_RCRC, ST_WCRC, ST_RESP_TX
    } sess_st_e;

    localparam logic [3:0] CRC_INIT = 4'h5;
    localparam logic [3:0] CRC_POLY = 4'hC;

    function automatic logic type_ok(input logic [1:0] t);
        return t != 2'd3;
    endfunction

    function automatic int cmd_bits(input logic [1:0] t);
        case (t)
            2'd0:    return 6;
            2'd1:    return 9;
            default: return 11;
        endcase
    endfunction

    function automatic int addr_bits(input logic [1:0] t);
        return cmd_bits(t) - 1;
    endfunction

    function automatic logic [5:0] card_code(input logic [1:0] t);
        case (t)
            2'd0:    return 6'h0D;
            2'd1:    return 6'h1D;
            default: return 6'h3D;
        endcase
    endfunction

    function automatic logic [5:0] ack_code(input logic [1:0] t);
        return (t == 2'd0) ? 6'h19 : 6'h39;
    endfunction

endpackage

// File: rtl/tag_crc4.sv
module tag_crc4 #(
    parameter int WORD_W = 19,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  nbits,
    output logic              done,
    output logic [3:0]        crc
);
    import tag_sess_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic [3:0]        crc;
        logic              done;
    } crc_st_t;

    crc_st_t q, d;
    logic    fb;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        fb     = 1'b0;
        if (start) begin
            d.sh  = word;
            d.cnt = nbits;
            d.crc = CRC_INIT;
        end else if (q.cnt != '0) begin
            fb     = q.sh[q.cnt - CNT_W'(1)] ^ q.crc[3];
            d.crc  = {q.crc[2:0], 1'b0} ^ (fb ? CRC_POLY : 4'h0);
            d.cnt  = q.cnt - CNT_W'(1);
            d.done = (q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign crc  = q.crc;
endmodule

// File: rtl/tag_byte_ram.sv
module tag_byte_ram #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/tag_session_ctrl.sv
module tag_session_ctrl #(
    parameter int MAX_FRAME = 23,
    parameter int MAX_CMD   = 11,
    parameter int MEM_DEPTH = 1024,
    parameter int LEN_W     = $clog2(MAX_FRAME + 1),
    parameter int AW        = $clog2(MEM_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           tag_type,
    output logic                 rx_start,
    input  logic                 rx_done,
    input  logic                 rx_err,
    input  logic [LEN_W-1:0]     rx_len,
    input  logic [MAX_FRAME-1:0] rx_frame,
    output logic                 tx_start,
    output logic [3:0]           tx_len,
    output logic [11:0]          tx_frame,
    output logic                 tx_plain,
    input  logic                 tx_done,
    output logic                 ks_load,
    output logic [6:0]           ks_seed,
    output logic                 ts_bump,
    input  logic                 host_we,
    input  logic [AW-1:0]        host_addr,
    input  logic [7:0]           host_data
);
    import tag_sess_pkg::*;

    localparam int CRC_W  = MAX_CMD + 8;
    localparam int CCNT_W = $clog2(CRC_W + 1);

    typedef struct packed {
        sess_st_e           state;
        logic [1:0]         ttype;
        logic               rx_start;
        logic               tx_start;
        logic [3:0]         tx_len;
        logic [11:0]        tx_frame;
        logic               tx_plain;
        logic               ks_load;
        logic [6:0]         ks_seed;
        logic               ts_bump;
        logic [MAX_CMD-1:0] cmd;
        logic [AW-1:0]      addr;
        logic [7:0]         wbyte;
        logic [7:0]         rbyte;
        logic [3:0]         crc_rx;
    } sess_t;

    sess_t q, d;

    int                 c_bits, a_bits;
    logic [AW-1:0]      rx_addr;
    logic [7:0]         rx_byte;
    logic [3:0]         rx_crc;
    logic [MAX_CMD-1:0] rx_cmd;
    logic               rx_ok;
    logic               crc_go, crc_done;
    logic [CRC_W-1:0]   crc_word;
    logic [3:0]         crc_val;
    logic               fsm_re, fsm_we;
    logic               ram_we;
    logic [AW-1:0]      ram_addr;
    logic [7:0]         ram_wdata, ram_rdata;

    // field slicing for the latched size class
    always_comb begin
        c_bits  = cmd_bits(q.ttype);
        a_bits  = addr_bits(q.ttype);
        rx_addr = AW'((32'(rx_frame) >> 1) & ((32'd1 << a_bits) - 32'd1));
        rx_byte = 8'(32'(rx_frame) >> c_bits);
        rx_crc  = 4'(32'(rx_frame) >> (c_bits + 8));
        rx_cmd  = MAX_CMD'(32'(rx_frame) & ((32'd1 << c_bits) - 32'd1));
        rx_ok   = rx_done && !rx_err;
    end

    always_comb begin
        d          = q;
        d.rx_start = 1'b0;
        d.tx_start = 1'b0;
        d.tx_plain = 1'b0;
        d.ks_load  = 1'b0;
        d.ts_bump  = 1'b0;
        crc_go     = 1'b0;
        crc_word   = '0;
        fsm_re     = 1'b0;
        fsm_we     = 1'b0;
        case (q.state)
            ST_IDLE: if (type_ok(tag_type)) begin
                d.ttype    = tag_type;
                d.ks_load  = 1'b1;
                d.ks_seed  = '0;
                d.rx_start = 1'b1;
                d.state    = ST_IV;
            end
            ST_IV: if (rx_done) begin
                if (rx_ok && rx_len == LEN_W'(7)) begin
                    d.ks_load  = 1'b1;
                    d.ks_seed  = rx_frame[6:0];
                    d.tx_start = 1'b1;
                    d.tx_len   = 4'd6;
                    d.tx_frame = {6'd0, card_code(q.ttype)};
                    d.state    = ST_TYPE_TX;
                end else d.state = ST_IDLE;
            end
            ST_TYPE_TX: if (tx_done) begin
                d.rx_start = 1'b1;
                d.state    = ST_ACK;
            end
            ST_ACK: if (rx_done) begin
                if (rx_ok && rx_len == LEN_W'(6) && rx_frame[5:0] == ack_code(q.ttype)) begin
                    d.ts_bump  = 1'b1;
                    d.rx_start = 1'b1;
                    d.state    = ST_CMD;
                end else d.state = ST_IDLE;
            end
            ST_CMD: if (rx_done) begin
                if (!rx_ok) d.state = ST_IDLE;
                else if (rx_len == LEN_W'(c_bits)) begin
                    fsm_re  = 1'b1;
                    d.cmd   = rx_cmd;
                    d.state = ST_RD;
                end else if (rx_len == LEN_W'(c_bits + 12)) begin
                    d.addr   = rx_addr;
                    d.wbyte  = rx_byte;
                    d.crc_rx = rx_crc;
                    crc_go   = 1'b1;
                    crc_word = (CRC_W'(rx_byte) << c_bits) | (CRC_W'(rx_addr) << 1);
                    d.state  = ST_WCRC;
                end else d.state = ST_IDLE;
            end
            ST_RD: begin
                d.rbyte  = ram_rdata;
                crc_go   = 1'b1;
                crc_word = (CRC_W'(ram_rdata) << c_bits) | CRC_W'(q.cmd);
                d.state  = ST_RCRC;
            end
            ST_RCRC: if (crc_done) begin
                d.tx_start = 1'b1;
                d.tx_len   = 4'd12;
                d.tx_frame = {crc_val, q.rbyte};
                d.state    = ST_RESP_TX;
            end
            ST_WCRC: if (crc_done) begin
                if (crc_val == q.crc_rx) begin
                    fsm_we     = 1'b1;
                    d.tx_start = 1'b1;
                    d.tx_plain = 1'b1;
                    d.tx_len   = 4'd1;
                    d.tx_frame = 12'd1;
                    d.state    = ST_RESP_TX;
                end else d.state = ST_IDLE;
            end
            ST_RESP_TX: if (tx_done) begin
                d.rx_start = 1'b1;
                d.state    = ST_CMD;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // store port arbitration: controller first, host otherwise
    always_comb begin
        if (fsm_we) begin
            ram_we = 1'b1; ram_addr = q.addr; ram_wdata = q.wbyte;
        end else if (fsm_re) begin
            ram_we = 1'b0; ram_addr = rx_addr; ram_wdata = host_data;
        end else begin
            ram_we = host_we; ram_addr = host_addr; ram_wdata = host_data;
        end
    end

    tag_crc4 #(.WORD_W(CRC_W), .CNT_W(CCNT_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .start(crc_go), .word(crc_word),
        .nbits(CCNT_W'(c_bits + 8)), .done(crc_done), .crc(crc_val)
    );

    tag_byte_ram #(.DEPTH(MEM_DEPTH), .AW(AW)) u_ram (
        .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
    );

    assign rx_start = q.rx_start;
    assign tx_start = q.tx_start;
    assign tx_len   = q.tx_len;
    assign tx_frame = q.tx_frame;
    assign tx_plain = q.tx_plain;
    assign ks_load  = q.ks_load;
    assign ks_seed  = q.ks_seed;
    assign ts_bump  = q.ts_bump;
endmodule

// File: rtl/tag_sess_chk.sv
module tag_sess_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  tag_type,
    input logic        rx_start,
    input logic        tx_start,
    input logic [3:0]  tx_len,
    input logic [11:0] tx_frame,
    input logic        tx_plain,
    input logic        ks_load,
    input logic [6:0]  ks_seed,
    input logic        ts_bump
);
    AST_OPEN_TYPE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_start && ks_load) |-> ($past(tag_type) != 2'd3)); // R1
    AST_OPEN_SEED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_start && ks_load) |-> (ks_seed == 7'd0)); // R2
    AST_RESEED_WITH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_load && !rx_start) |-> (tx_start && tx_len == 4'd6)); // R3
    AST_BUMP_WITH_CMD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ts_bump |-> (rx_start && !ks_load)); // R5
    AST_BUMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ts_bump |=> !ts_bump); // R5
    AST_TX_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (tx_len == 4'd6 || tx_len == 4'd12 || tx_len == 4'd1)); // R6
    AST_PLAIN_IS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_plain |-> (tx_start && tx_len == 4'd1 && tx_frame == 12'd1)); // R8
    AST_NO_TX_RX_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_start && rx_start)); // R10
endmodule

bind tag_session_ctrl tag_sess_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tag_type(tag_type), .rx_start(rx_start),
    .tx_start(tx_start), .tx_len(tx_len), .tx_frame(tx_frame), .tx_plain(tx_plain),
    .ks_load(ks_load), .ks_seed(ks_seed), .ts_bump(ts_bump)
);

// File: tb/tag_session_ctrl_tb.sv
module tag_session_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  tag_type = 2'd3;
    logic        rx_start, rx_done = 1'b0, rx_err = 1'b0;
    logic [4:0]  rx_len = '0;
    logic [22:0] rx_frame = '0;
    logic        tx_start, tx_plain, tx_done = 1'b0;
    logic [3:0]  tx_len;
    logic [11:0] tx_frame;
    logic        ks_load, ts_bump;
    logic [6:0]  ks_seed;
    logic        host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [7:0]  host_data = '0;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mdl [1024];

    always #(CLK_PERIOD/2) clk = ~clk;

    tag_session_ctrl u_dut (.*);

    // {is_write, addr, data}
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 8'h10, 8'h00}, {1'b1, 8'h10, 8'h5A}, {1'b0, 8'h10, 8'h00},
        {1'b1, 8'hFF, 8'h01}, {1'b0, 8'hFF, 8'h00}, {1'b0, 8'h20, 8'h00},
        {1'b1, 8'h00, 8'hFF}, {1'b0, 8'h00, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] crc4(input logic [18:0] w, input int n);
        logic [3:0] r = 4'h5;
        logic fb;
        for (int i = n - 1; i >= 0; i--) begin
            fb = w[i] ^ r[3];
            r  = {r[2:0], 1'b0} ^ (fb ? 4'hC : 4'h0);
        end
        return r;
    endfunction

    // returns at a negedge where rx_start is high
    task automatic wait_rx(output bit fresh, output bit tsb);
        int n = 0;
        while (!rx_start && n < 400) begin @(negedge clk); n++; end
        fresh = rx_start && ks_load && ks_seed == 7'd0;
        tsb   = ts_bump;
        if (!rx_start) chk(1'b0, "timeout waiting rx_start", 0, 1);
    endtask

    task automatic send_rx(input int len, input logic [22:0] f, input bit err);
        rx_done = 1'b1; rx_len = 5'(len); rx_frame = f; rx_err = err;
        @(negedge clk);
        rx_done = 1'b0; rx_err = 1'b0;
    endtask

    task automatic wait_tx(output logic [3:0] l, output logic [11:0] f, output bit p, output logic [6:0] seed);
        int n = 0;
        while (!tx_start && n < 400) begin @(negedge clk); n++; end
        l = tx_len; f = tx_frame; p = tx_plain; seed = ks_load ? ks_seed : 7'h7F;
        if (!tx_start) chk(1'b0, "timeout waiting tx_start", 0, 1);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    function automatic logic [5:0] card_of(input logic [1:0] t);
        return t == 2'd0 ? 6'h0D : (t == 2'd1 ? 6'h1D : 6'h3D);
    endfunction

    task automatic do_setup(input logic [1:0] t, input logic [6:0] iv);
        logic [3:0] l; logic [11:0] f; bit p, fr, tb; logic [6:0] s;
        send_rx(7, 23'(iv), 1'b0);
        wait_tx(l, f, p, s);
        chk(l == 4'd6 && f == 12'(card_of(t)), "R3 card code", f, card_of(t));
        chk(s == iv, "R3 reseed with IV", s, iv);
        wait_rx(fr, tb);
        chk(!fr, "R3 session kept after code", fr, 0);
        send_rx(6, (t == 2'd0) ? 23'h19 : 23'h39, 1'b0);
        wait_rx(fr, tb);
        chk(tb && !fr, "R5 timer bump with first command request", {fr, tb}, 1);
    endtask

    task automatic do_read(input int c, input int a);
        logic [3:0] l; logic [11:0] f, e; bit p, fr, tb; logic [6:0] s;
        logic [22:0] fm = 23'((a << 1) | 1);
        send_rx(c, fm, 1'b0);
        wait_tx(l, f, p, s);
        e = {crc4((19'(mdl[a]) << c) | 19'(fm), c + 8), mdl[a]};
        chk(l == 4'd12 && f == e && !p, "R6 R7 read reply", f, e);
        wait_rx(fr, tb);
        chk(!fr, "R6 next command requested", fr, 0);
    endtask

    task automatic do_write(input int c, input int a, input logic [7:0] v, input bit bad);
        logic [3:0] l; logic [11:0] f; bit p, fr, tb; logic [6:0] s;
        logic [3:0] k = crc4((19'(v) << c) | (19'(a) << 1), c + 8) ^ {3'b0, bad};
        send_rx(c + 12, (23'(k) << (c + 8)) | (23'(v) << c) | (23'(a) << 1), 1'b0);
        if (!bad) begin
            wait_tx(l, f, p, s);
            chk(l == 4'd1 && f == 12'd1 && p, "R8 plain write ack", {p, l, f}, 17'h11001);
            mdl[a] = v;
            wait_rx(fr, tb);
            chk(!fr, "R8 session kept after write", fr, 0);
        end else begin
            wait_rx(fr, tb);
            chk(fr, "R9 bad check code restarts", fr, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit fr, tb;
        int seen;
        repeat (3) @(negedge clk);
        chk(!rx_start && !tx_start && !tx_plain && !ks_load && !ts_bump, "R12 reset outputs low",
            {rx_start, tx_start, tx_plain, ks_load, ts_bump}, 0);
        rst_n = 1'b1;
        seen = 0;
        repeat (50) begin @(negedge clk); if (rx_start) seen++; end
        chk(seen == 0, "R1 invalid type opens nothing", seen, 0);

        // host preload while idle
        for (int i = 0; i < 3; i++) begin
            host_we   = 1'b1;
            host_addr = (i == 0) ? 10'h10 : (i == 1) ? 10'h20 : 10'h3;
            host_data = (i == 0) ? 8'hA5 : (i == 1) ? 8'h3C : 8'h77;
            mdl[host_addr] = host_data;
            @(negedge clk);
        end
        host_we = 1'b0;

        tag_type = 2'd1;
        wait_rx(fr, tb);
        chk(fr, "R2 session opens with seed 0", fr, 1);
        do_setup(2'd1, 7'h55);
        do_read(9, 'h10);   // R11 preload visible

        for (int i = 0; i < 8; i++) begin
            if (VEC[i][16]) do_write(9, int'(VEC[i][15:8]), VEC[i][7:0], 1'b0);
            else            do_read(9, int'(VEC[i][15:8]));
        end

        do_write(9, 'h20, 8'h99, 1'b1);
        do_setup(2'd1, 7'h2A);
        do_read(9, 'h20);   // R9 byte unchanged

        send_rx(15, 23'h1234, 1'b0);
        wait_rx(fr, tb);
        chk(fr, "R10 unknown length restarts", fr, 1);
        do_setup(2'd1, 7'h01);
        send_rx(9, 23'h21, 1'b1);
        wait_rx(fr, tb);
        chk(fr, "R10 receive error restarts", fr, 1);

        send_rx(6, 23'h15, 1'b0);
        wait_rx(fr, tb);
        chk(fr, "R3 wrong IV length restarts", fr, 1);

        begin
            logic [3:0] l; logic [11:0] f; bit p; logic [6:0] s;
            send_rx(7, 23'h33, 1'b0);
            wait_tx(l, f, p, s);
            wait_rx(fr, tb);
            send_rx(6, 23'h19, 1'b0);
            wait_rx(fr, tb);
            chk(fr, "R4 wrong acknowledge restarts", fr, 1);
        end

        tag_type = 2'd0;
        send_rx(3, 23'h1, 1'b0);
        wait_rx(fr, tb);
        chk(fr, "R1 switch to type 0", fr, 1);
        do_setup(2'd0, 7'h11);
        do_read(6, 3);

        tag_type = 2'd2;
        send_rx(3, 23'h1, 1'b0);
        wait_rx(fr, tb);
        chk(fr, "R1 switch to type 2", fr, 1);
        do_setup(2'd2, 7'h7F);
        do_write(11, 'h3FF, 8'hC3, 1'b0);
        do_read(11, 'h3FF);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule